// File: doc/BRIEF.md
# SPI Flash Page Transfer Engine

This block is an SPI master sequencer that moves one whole page between a host and a serial flash memory which has an internal page buffer. The host supplies a page number and a direction, then pulses `start`. The block frames the whole transfer with one chip-select window. That window holds an opcode byte, three address bytes, and then the page data. In the read direction the window also holds four filler bytes. Read data flows to the host over a valid/ready byte stream. Write data is pulled from the host over a second valid/ready stream, one byte at a time, only when the shifter can take it.

When a write page has been sent, the block releases chip select. It then polls the device status in short frames of its own until the ready bit appears or a poll budget runs out. If the budget runs out, it raises `timeout` and finishes anyway.

After reset the block holds the device reset line low for a fixed number of cycles, with chip select high. Until the device reset line is released, the block ignores requests. SCK runs in mode 0 at the system clock divided by `SCK_DIV`.

Top module: `spi_page_xfer`

## Requirements
- R1: Chip select stays low without a break from the first opcode bit to the last data bit of a page frame, and the frame carries exactly `PAGE_BYTES` data bytes.
- R2: The three bytes after the opcode are `(page >> 6)` cut to 8 bits, then `(page << 2)` cut to 8 bits, then 0x00.
- R3: A read frame is opcode `RD_OP` (default 0xD2), the three address bytes, then `DUMMY_BYTES` (default 4) bytes of 0x00, then the data bytes. MOSI sends 0x00 for every byte clocked in.
- R4: A write frame is opcode `WR_OP` (default 0x82), the three address bytes, then the host bytes in order, with no filler. `wready` is high only when no byte is in flight.
- R5: Read bytes reach the host in page order, one per cycle in which `rvalid` and `rready` are both high. `rdata` is held stable while `rvalid` is high and `rready` is low.
- R6: After a write, each status poll is its own chip-select frame of exactly two bytes: opcode `ST_OP` (default 0xD7) out, then one byte in. Polling stops at the first status byte with bit 7 = 1 (ready).
- R7: If `POLL_MAX` polls all return bit 7 = 0, `timeout` rises and the operation still completes. `timeout` stays low on any operation that sees ready, and a new start clears it.
- R8: SCK is low whenever no byte is shifting. Bits go MSB first. MISO is sampled on the rising edge, and the SCK high phase lasts `SCK_DIV/2` clocks.
- R9: After reset, `dev_rst_n` is low for `RST_CYCLES` clocks while `cs_n` is high and `busy` is high. A `start` in that window is ignored.
- R10: `busy` is high from an accepted start until the operation ends. `done` is a one-cycle pulse, given after chip select has returned high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one page operation (accepted when not busy) |
| wr | input | 1 | Direction with start: 1 write, 0 read |
| page | input | PAGE_W | Page number with start |
| busy | output | 1 | Operation in progress or device still in reset |
| done | output | 1 | One-cycle end-of-operation pulse |
| timeout | output | 1 | Last write never saw ready during polling |
| wdata | input | 8 | Write byte from host |
| wvalid | input | 1 | Write byte valid |
| wready | output | 1 | Block takes the write byte this cycle |
| rdata | output | 8 | Read byte to host |
| rvalid | output | 1 | Read byte valid |
| rready | input | 1 | Host takes the read byte |
| cs_n | output | 1 | Device chip select, active low |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to device |
| miso | input | 1 | Serial data from device |
| dev_rst_n | output | 1 | Device reset line, active low |

## Verification
The assertions check the framing invariants on every cycle. They cover chip select held low around each shifted byte and SCK resting low between bytes. They also cover write-stream back-pressure, the hold on a stalled read byte, the reset-window quiet, and the shape of the done pulse and its ordering after a timeout. Only the bench scenarios can show byte content. That means the address arithmetic across many page numbers, the filler bytes, the write data order, and the read data order under host stalls. The bench also sweeps the count of status frames against device busy lengths below, at and above the poll budget.

// File: rtl/spi_page_pkg.sv
package spi_page_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_HDR,
    SQ_DATA,
    SQ_GAP,
    SQ_POLL,
    SQ_DONE
  } seq_state_t;

  localparam int ADDR_BYTES = 3;

  // Address byte k (0..2) of the command header for a given page
  function automatic logic [7:0] addr_byte(input logic [31:0] pg, input int unsigned k);
    if (k == 0) return 8'(pg >> 6);
    if (k == 1) return 8'(pg << 2);
    return 8'h00;
  endfunction

  // Header byte k: opcode, then address bytes, then zero filler
  function automatic logic [7:0] hdr_byte(input logic [7:0] op, input logic [31:0] pg,
                                          input int unsigned k);
    if (k == 0) return op;
    if (k <= ADDR_BYTES) return addr_byte(pg, k - 1);
    return 8'h00;
  endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int SCK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx
);
  localparam int HALF = SCK_DIV / 2;
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    tsh;
  logic [7:0]    rsh;

  assign mosi = tsh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bitn <= '0;
      tsh  <= '0;
      rsh  <= '0;
      rx   <= '0;
      sck  <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        busy <= 1'b1;
        tsh  <= tx;
        cnt  <= '0;
        bitn <= '0;
        sck  <= 1'b0;
      end else if (busy) begin
        if (cnt == HALF_LAST) begin
          cnt <= '0;
          if (!sck) begin
            sck <= 1'b1;
            rsh <= {rsh[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bitn == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
              rx   <= rsh;
            end else begin
              bitn <= bitn + 3'd1;
              tsh  <= {tsh[6:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_dev_reset.sv
module spi_dev_reset #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic dev_rst_n
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      dev_rst_n <= 1'b0;
    end else if (!dev_rst_n) begin
      if (cnt == LAST) dev_rst_n <= 1'b1;
      else             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_page_fsm.sv
module spi_page_fsm
  import spi_page_pkg::*;
#(
  parameter int          PAGE_BYTES  = 512,
  parameter int          PAGE_W      = 16,
  parameter int          DUMMY_BYTES = 4,
  parameter int          POLL_MAX    = 10000,
  parameter logic [7:0]  RD_OP       = 8'hD2,
  parameter logic [7:0]  WR_OP       = 8'h82,
  parameter logic [7:0]  ST_OP       = 8'hD7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_ready,
  input  logic              start,
  input  logic              wr,
  input  logic [PAGE_W-1:0] page,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  input  logic [7:0]        wdata,
  input  logic              wvalid,
  output logic              wready,
  output logic [7:0]        rdata,
  output logic              rvalid,
  input  logic              rready,
  output logic              cs_n,
  output logic              sh_go,
  output logic [7:0]        sh_tx,
  input  logic              sh_busy,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx
);
  localparam int IDX_W = $clog2(PAGE_BYTES + DUMMY_BYTES + ADDR_BYTES + 2);
  localparam int PC_W  = $clog2(POLL_MAX + 1);
  localparam logic [IDX_W-1:0] LAST_DATA   = IDX_W'(PAGE_BYTES - 1);
  localparam logic [IDX_W-1:0] RD_HDR_LAST = IDX_W'(ADDR_BYTES + DUMMY_BYTES);
  localparam logic [IDX_W-1:0] WR_HDR_LAST = IDX_W'(ADDR_BYTES);
  localparam logic [PC_W-1:0]  POLL_LAST   = PC_W'(POLL_MAX - 1);

  seq_state_t        state;
  logic [IDX_W-1:0]  idx;
  logic [PC_W-1:0]   polls;
  logic [PAGE_W-1:0] page_q;
  logic              wr_q;
  logic              inflight;
  logic [IDX_W-1:0]  hdr_last;

  assign hdr_last = wr_q ? WR_HDR_LAST : RD_HDR_LAST;
  assign wready   = (state == SQ_DATA) && wr_q && !inflight;
  assign busy     = (state != SQ_IDLE) || !dev_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      idx      <= '0;
      polls    <= '0;
      page_q   <= '0;
      wr_q     <= 1'b0;
      inflight <= 1'b0;
      done     <= 1'b0;
      timeout  <= 1'b0;
      rdata    <= '0;
      rvalid   <= 1'b0;
      cs_n     <= 1'b1;
      sh_go    <= 1'b0;
      sh_tx    <= '0;
    end else begin
      sh_go <= 1'b0;
      done  <= 1'b0;
      case (state)
        SQ_IDLE: if (start && dev_ready) begin
          page_q  <= page;
          wr_q    <= wr;
          idx     <= '0;
          polls   <= '0;
          timeout <= 1'b0;
          cs_n    <= 1'b0;
          state   <= SQ_HDR;
        end
        SQ_HDR: begin
          if (!inflight && !sh_busy) begin
            sh_go    <= 1'b1;
            sh_tx    <= hdr_byte(wr_q ? WR_OP : RD_OP, 32'(page_q), 32'(idx));
            inflight <= 1'b1;
          end else if (inflight && sh_done) begin
            inflight <= 1'b0;
            if (idx == hdr_last) begin
              idx   <= '0;
              state <= SQ_DATA;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        SQ_DATA: begin
          if (wr_q) begin
            if (wvalid && wready) begin
              sh_go    <= 1'b1;
              sh_tx    <= wdata;
              inflight <= 1'b1;
            end else if (inflight && sh_done) begin
              inflight <= 1'b0;
              if (idx == LAST_DATA) begin
                cs_n  <= 1'b1;
                state <= SQ_GAP;
              end else begin
                idx <= idx + 1'b1;
              end
            end
          end else begin
            if (!inflight && !rvalid) begin
              sh_go    <= 1'b1;
              sh_tx    <= 8'h00;
              inflight <= 1'b1;
            end else if (inflight && sh_done) begin
              inflight <= 1'b0;
              rdata    <= sh_rx;
              rvalid   <= 1'b1;
            end else if (rvalid && rready) begin
              rvalid <= 1'b0;
              if (idx == LAST_DATA) begin
                cs_n  <= 1'b1;
                state <= SQ_DONE;
              end else begin
                idx <= idx + 1'b1;
              end
            end
          end
        end
        SQ_GAP: begin
          cs_n  <= 1'b0;
          idx   <= '0;
          state <= SQ_POLL;
        end
        SQ_POLL: begin
          if (!inflight && !sh_busy) begin
            sh_go    <= 1'b1;
            sh_tx    <= (idx == '0) ? ST_OP : 8'h00;
            inflight <= 1'b1;
          end else if (inflight && sh_done) begin
            inflight <= 1'b0;
            if (idx == '0) begin
              idx <= idx + 1'b1;
            end else begin
              cs_n  <= 1'b1;
              polls <= polls + 1'b1;
              if (sh_rx[7]) begin
                state <= SQ_DONE;
              end else if (polls == POLL_LAST) begin
                timeout <= 1'b1;
                state   <= SQ_DONE;
              end else begin
                state <= SQ_GAP;
              end
            end
          end
        end
        SQ_DONE: begin
          done  <= 1'b1;
          state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_page_xfer.sv
module spi_page_xfer #(
  parameter int          PAGE_BYTES  = 512,
  parameter int          PAGE_W      = 16,
  parameter int          DUMMY_BYTES = 4,
  parameter int          SCK_DIV     = 2,
  parameter int          POLL_MAX    = 10000,
  parameter int          RST_CYCLES  = 16,
  parameter logic [7:0]  RD_OP       = 8'hD2,
  parameter logic [7:0]  WR_OP       = 8'h82,
  parameter logic [7:0]  ST_OP       = 8'hD7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr,
  input  logic [PAGE_W-1:0] page,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  input  logic [7:0]        wdata,
  input  logic              wvalid,
  output logic              wready,
  output logic [7:0]        rdata,
  output logic              rvalid,
  input  logic              rready,
  output logic              cs_n,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              dev_rst_n
);
  // Internal events brought out for the checker
  logic       sh_go;
  logic [7:0] sh_tx;
  logic       sh_busy;
  logic       sh_done;
  logic [7:0] sh_rx;

  spi_dev_reset #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_rst_n(dev_rst_n)
  );

  spi_byte_shifter #(.SCK_DIV(SCK_DIV)) u_shift (
    .clk (clk),
    .rst_n(rst_n),
    .go  (sh_go),
    .tx  (sh_tx),
    .miso(miso),
    .sck (sck),
    .mosi(mosi),
    .busy(sh_busy),
    .done(sh_done),
    .rx  (sh_rx)
  );

  spi_page_fsm #(
    .PAGE_BYTES (PAGE_BYTES),
    .PAGE_W     (PAGE_W),
    .DUMMY_BYTES(DUMMY_BYTES),
    .POLL_MAX   (POLL_MAX),
    .RD_OP      (RD_OP),
    .WR_OP      (WR_OP),
    .ST_OP      (ST_OP)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_ready(dev_rst_n),
    .start    (start),
    .wr       (wr),
    .page     (page),
    .busy     (busy),
    .done     (done),
    .timeout  (timeout),
    .wdata    (wdata),
    .wvalid   (wvalid),
    .wready   (wready),
    .rdata    (rdata),
    .rvalid   (rvalid),
    .rready   (rready),
    .cs_n     (cs_n),
    .sh_go    (sh_go),
    .sh_tx    (sh_tx),
    .sh_busy  (sh_busy),
    .sh_done  (sh_done),
    .sh_rx    (sh_rx)
  );
endmodule

// File: rtl/spi_page_xfer_chk.sv
module spi_page_xfer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic       dev_rst_n,
  input logic       busy,
  input logic       done,
  input logic       timeout,
  input logic       wready,
  input logic       rvalid,
  input logic       rready,
  input logic [7:0] rdata,
  input logic       sh_go,
  input logic       sh_busy
);
  AST_CS_HELD_IN_BYTE: assert property (@(posedge clk) disable iff (!rst_n) sh_busy |-> !cs_n); // R1
  AST_ONE_BYTE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n) sh_go |-> !sh_busy); // R1
  AST_WREADY_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) wready |-> (!sh_busy && !sh_go && !cs_n)); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rvalid && !rready) |=> (rvalid && $stable(rdata))); // R5
  AST_TIMEOUT_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(timeout) |=> done); // R7
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !sh_busy |-> !sck); // R8
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !dev_rst_n |-> (cs_n && busy)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n) done |-> (cs_n && !busy)); // R10
endmodule

bind spi_page_xfer spi_page_xfer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .sck      (sck),
  .dev_rst_n(dev_rst_n),
  .busy     (busy),
  .done     (done),
  .timeout  (timeout),
  .wready   (wready),
  .rvalid   (rvalid),
  .rready   (rready),
  .rdata    (rdata),
  .sh_go    (sh_go),
  .sh_busy  (sh_busy)
);

// File: tb/spi_page_xfer_bench.sv
module spi_page_xfer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PB   = 8;
  localparam int DIV  = 4;
  localparam int PMAX = 5;
  localparam int RSTC = 6;
  localparam int PW   = 12;
  localparam logic [7:0] OP_RD = 8'hD2;
  localparam logic [7:0] OP_WR = 8'h82;
  localparam logic [7:0] OP_ST = 8'hD7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wr = 1'b0;
  logic [PW-1:0] page = '0;
  logic busy, done, timeout;
  logic [7:0] wdata = '0;
  logic wvalid = 1'b0, wready;
  logic [7:0] rdata;
  logic rvalid, rready = 1'b0;
  logic cs_n, sck, mosi, dev_rst_n;
  logic miso = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_page_xfer #(
    .PAGE_BYTES(PB), .PAGE_W(PW), .DUMMY_BYTES(4), .SCK_DIV(DIV),
    .POLL_MAX(PMAX), .RST_CYCLES(RSTC)
  ) u_spi_page_xfer (
    .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .page(page),
    .busy(busy), .done(done), .timeout(timeout),
    .wdata(wdata), .wvalid(wvalid), .wready(wready),
    .rdata(rdata), .rvalid(rvalid), .rready(rready),
    .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso), .dev_rst_n(dev_rst_n)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rpat(input int a1, input int a2, input int k);
    return 8'((a1 * 7) ^ (a2 * 3) ^ (k * 37 + 5));
  endfunction

  function automatic logic [7:0] wpat(input int pg, input int k);
    return 8'(pg * 13 + k * 29 + 1);
  endfunction

  // ---------------- device model ----------------
  logic sck_q = 1'b0, cs_q = 1'b1;
  int m_bits = 0;
  logic [7:0] m_sh = '0;
  logic [7:0] m_cap [32];
  logic [7:0] main_cap [32];
  int main_len = 0;
  int st_busy_left = 0, st_frames = 0, st_badlen = 0;
  int hi_run = 0, hi_min = 1000, hi_max = 0;

  function automatic logic [7:0] m_out(input int bi);
    if (bi >= 1 && m_cap[0] == OP_ST) return (st_busy_left > 0) ? 8'h1C : 8'h9C;
    if (bi >= 8 && m_cap[0] == OP_RD) return rpat(int'(m_cap[1]), int'(m_cap[2]), bi - 8);
    return 8'h00;
  endfunction

  always @(negedge clk) begin
    logic [7:0] ob;
    if (cs_n) begin
      if (!cs_q) begin
        if (m_cap[0] == OP_ST) begin
          st_frames++;
          if (m_bits != 16) st_badlen++;
          if (st_busy_left > 0) st_busy_left--;
        end else begin
          main_len = m_bits / 8;
          for (int i = 0; i < 32; i++) main_cap[i] = m_cap[i];
        end
      end
      m_bits = 0;
      miso = 1'b0;
    end else if (sck && !sck_q) begin
      m_sh = {m_sh[6:0], mosi};
      m_bits++;
      if (m_bits % 8 == 0 && m_bits / 8 <= 32) m_cap[m_bits/8 - 1] = m_sh;
      ob = m_out(m_bits / 8);
      miso = ob[7 - (m_bits % 8)];
    end
    if (sck) hi_run++;
    else if (hi_run > 0) begin
      if (hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
      hi_run = 0;
    end
    sck_q = sck;
    cs_q = cs_n;
  end

  // ---------------- tasks ----------------
  task automatic pulse_start(input bit w, input int pg);
    @(negedge clk);
    wr = w; page = PW'(pg); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
  endtask

  task automatic check_header(input int pg, input logic [7:0] op, input string req);
    chk(main_cap[0] == op, req, int'(main_cap[0]), int'(op));
    chk(main_cap[1] == 8'(pg >> 6), "R2 addr byte0", int'(main_cap[1]), int'(8'(pg >> 6)));
    chk(main_cap[2] == 8'(pg << 2), "R2 addr byte1", int'(main_cap[2]), int'(8'(pg << 2)));
    chk(main_cap[3] == 8'h00, "R2 addr byte2", int'(main_cap[3]), 0);
  endtask

  task automatic do_read(input int pg, input int stall_mod);
    logic [7:0] got [PB];
    int n = 0;
    int cyc = 0;
    bit seen = 0;
    bit dz = 1;
    st_frames = 0;
    pulse_start(1'b0, pg);
    while (!seen && cyc < 20000) begin
      rready = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) != 0);
      if (rvalid && rready && n < PB) begin got[n] = rdata; n++; end
      if (done) seen = 1;
      @(negedge clk);
      cyc++;
    end
    rready = 1'b0;
    chk(seen, "R10 read done seen", int'(seen), 1);
    chk(n == PB, "R5 read byte count", n, PB);
    for (int i = 0; i < PB; i++)
      chk(got[i] == rpat(pg >> 6 & 255, (pg << 2) & 255, i), "R5 read data order",
          int'(got[i]), int'(rpat(pg >> 6 & 255, (pg << 2) & 255, i)));
    chk(main_len == 8 + PB, "R1 read frame length", main_len, 8 + PB);
    check_header(pg, OP_RD, "R3 read opcode");
    for (int i = 4; i < 8 + PB; i++) if (main_cap[i] != 8'h00) dz = 0;
    chk(dz, "R3 dummy and receive bytes zero on MOSI", int'(dz), 1);
    chk(timeout == 1'b0, "R7 no timeout on read", int'(timeout), 0);
    chk(st_frames == 0, "R6 no polling after read", st_frames, 0);
  endtask

  task automatic do_write(input int pg, input int busy_n, input int gap_mod);
    int n = 0;
    int cyc = 0;
    bit seen = 0;
    bit dok = 1;
    int exp_polls;
    st_busy_left = busy_n; st_frames = 0; st_badlen = 0;
    pulse_start(1'b1, pg);
    while (!seen && cyc < 20000) begin
      wvalid = (n < PB) && ((gap_mod == 0) || ((cyc % gap_mod) != 0));
      wdata = wpat(pg, n);
      if (wvalid && wready) n++;
      if (done) seen = 1;
      @(negedge clk);
      cyc++;
    end
    wvalid = 1'b0;
    exp_polls = (busy_n + 1 <= PMAX) ? busy_n + 1 : PMAX;
    chk(seen, "R10 write done seen", int'(seen), 1);
    chk(n == PB, "R4 write handshakes", n, PB);
    chk(main_len == 4 + PB, "R1 write frame length", main_len, 4 + PB);
    check_header(pg, OP_WR, "R4 write opcode");
    for (int i = 0; i < PB; i++) if (main_cap[4 + i] != wpat(pg, i)) dok = 0;
    chk(dok, "R4 write data order", int'(dok), 1);
    chk(st_frames == exp_polls, "R6 status frame count", st_frames, exp_polls);
    chk(st_badlen == 0, "R6 status frame is two bytes", st_badlen, 0);
    chk(timeout == (busy_n >= PMAX), "R7 timeout flag", int'(timeout), int'(busy_n >= PMAX));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    int rstlow = 0;
    int csbad = 0;
    int pages [10] = '{0, 1, 63, 64, 255, 256, 1023, 4095, 2748, 1365};
    for (int i = 0; i < 32; i++) begin m_cap[i] = '0; main_cap[i] = '0; end
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R9 cs high in reset", int'(cs_n), 1);
    chk(sck == 1'b0, "R8 sck low in reset", int'(sck), 0);
    chk(busy == 1'b1, "R9 busy in reset", int'(busy), 1);
    chk(done == 1'b0, "R10 no done in reset", int'(done), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (!dev_rst_n) rstlow++;
      if (!cs_n) csbad++;
      start = (i == 2);
      wr = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(rstlow == RSTC, "R9 device reset length", rstlow, RSTC);
    chk(csbad == 0, "R9 start ignored in device reset", csbad, 0);
    chk(busy == 1'b0, "R9 idle after device reset", int'(busy), 0);

    for (int i = 0; i < 10; i++) begin
      do_read(pages[i], (i % 2 == 0) ? 0 : 3);
      do_write(pages[i], i % 3, (i % 2 == 0) ? 0 : 4);
    end
    for (int b = 0; b <= PMAX + 1; b++) do_write(291, b, 0);
    do_write(4094, 0, 0);
    chk(timeout == 1'b0, "R7 timeout cleared by new start", int'(timeout), 0);

    chk(hi_min == DIV / 2, "R8 sck high phase min", hi_min, DIV / 2);
    chk(hi_max == DIV / 2, "R8 sck high phase max", hi_max, DIV / 2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule